// File: doc/BRIEF.md
# Two-Output Level Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines and presents them to a processor as two request outputs. Software reaches it through a simple word-wide register bus with a one-cycle read/write strobe. Each source has an enable bit in a mask. The mask is never written directly: one register sets the mask bits marked by ones in the written word, and another register clears them. The top mask bit is a global gate that silences both outputs when it is clear.

A steering register holds one bit per source. That bit decides which of the two outputs an enabled source drives. Software can read back the unmasked input levels and, for each output, the word of sources that are both enabled and steered to it. Each output line is the registered OR of its own status word. Sources are pure levels: a request stays pending until the source line drops, and no register acknowledges or clears it.

Top module: `intc_dual_out`

## Requirements
- R1: After reset the enable mask and the steering register are zero, both output lines are low and the read data port is zero.
- R2: A write to byte offset 0x34 sets each mask bit whose written data bit is 1. Mask bits whose data bit is 0 keep their value.
- R3: A write to byte offset 0x38 clears each mask bit whose written data bit is 1. Writing all ones clears the whole mask, including bit 31.
- R4: While mask bit 31 (the global gate) is 0, both output lines stay low and the status words at 0x00 and 0x04 read as zero, whatever the sources and the other mask bits are.
- R5: Steering register bit i, at offset 0x20, sends source i to output 0 when it is 0 and to output 1 when it is 1. A source never appears in both status words.
- R6: Offset 0x30 reads the current source levels with no masking, no steering and no dependence on the global gate.
- R7: Offset 0x00 reads source AND mask AND NOT steer, and offset 0x04 reads source AND mask AND steer. Both are forced to zero when the global gate is 0, and bit 31 of both words always reads 0.
- R8: Output line k is the OR of status word k and is registered, so it changes on the first clock edge after the sources or the mask change.
- R9: Offset 0x34 reads back the mask, offset 0x20 reads back the steering register, offset 0x38 reads as zero, and any unmapped offset reads as zero.
- R10: Sources are level-sensitive. Reading a status word does not clear it, and a status bit stays set only while its source is high.
- R11: Read data is captured on the clock edge where a read strobe is seen and is valid from the next cycle. It holds its value while no read strobe is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_i | input | 32 | Level-sensitive interrupt sources |
| irq0_o | output | 1 | Request line for output 0 |
| irq1_o | output | 1 | Request line for output 1 |

## Verification
The sources are driven with patterns that include a few low sources, all sources high, and sources that drop while enabled. The mask is built up and torn down with partial sets, partial clears and an all-ones clear. Steering a single source over to output 1 shows whether the two status words are split by the steering bit or copied. Toggling only the global gate with the other enables held shows whether it gates both outputs, and the all-high pattern shows that bit 31 is left out of the status words.

// File: rtl/intc_pkg.sv
// Package: shared register-select type and the address decode for the
// two-output interrupt controller.
// Assumes word-aligned byte offsets; the two low address bits are ignored.
package intc_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT0,
        SEL_STAT1,
        SEL_STEER,
        SEL_RAW,
        SEL_ENSET,
        SEL_ENCLR
    } reg_sel_e;

    localparam int unsigned DEC_W = 16;

    // Map a byte offset onto the register it selects.
    function automatic reg_sel_e decode_off(input logic [DEC_W-1:0] off);
        reg_sel_e s;
        case (off[DEC_W-1:2])
            14'h00:  s = SEL_STAT0;
            14'h01:  s = SEL_STAT1;
            14'h08:  s = SEL_STEER;
            14'h0C:  s = SEL_RAW;
            14'h0D:  s = SEL_ENSET;
            14'h0E:  s = SEL_ENCLR;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/intc_ctrl_regs.sv
// Module: holds the enable mask and the steering register.
// The mask changes only through set and clear writes. The steering
// register is written whole. Assumes at most one write per cycle.
module intc_ctrl_regs
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  reg_sel_e           wr_sel,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] steer_q
);

    logic [NUM_SRC-1:0] mask_d;
    logic [NUM_SRC-1:0] steer_d;

    // Next-state of the mask and the steering word from the decoded write.
    always_comb begin
        mask_d  = mask_q;
        steer_d = steer_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_ENSET: mask_d  = mask_q | wr_data;
                SEL_ENCLR: mask_d  = mask_q & ~wr_data;
                SEL_STEER: steer_d = wr_data;
                default:   ;
            endcase
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            steer_q <= '0;
        end else begin
            mask_q  <= mask_d;
            steer_q <= steer_d;
        end
    end

endmodule

// File: rtl/intc_steer.sv
// Module: forms the masked, steered status word for each output.
// The top source bit is the global gate, so it never shows in a status
// word. Purely combinational.
module intc_steer #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_OUT = 2
) (
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0] steer_i,
    output logic [NUM_SRC-1:0] stat_o [NUM_OUT]
);

    localparam int unsigned GBIT = NUM_SRC - 1;

    logic gate_on;

    // Global gate taken from the top mask bit.
    always_comb gate_on = mask_i[GBIT];

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
            if (i == GBIT) begin : g_gate
                // The gate position carries no source.
                always_comb stat_o[k][i] = 1'b0;
            end else begin : g_src
                // Source i goes to output k when its steer bit matches k.
                always_comb stat_o[k][i] = raw_i[i] & mask_i[i] & gate_on
                                         & (steer_i[i] == k[0]);
            end
        end
    end

endmodule

// File: rtl/intc_irq_line.sv
// Module: registered request line, the OR of one status word.
// Adds one clock of latency from source or mask change to the line.
module intc_irq_line #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] stat_i,
    output logic               irq_q
);

    // Register the reduction of the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |stat_i;
    end

endmodule

// File: rtl/intc_rd_mux.sv
// Module: registered read path. Captures the selected word when a read
// strobe is seen and holds it otherwise. Unmapped and clear offsets give 0.
module intc_rd_mux
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  reg_sel_e           rd_sel,
    input  logic [NUM_SRC-1:0] stat0_i,
    input  logic [NUM_SRC-1:0] stat1_i,
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0] steer_i,
    output logic [NUM_SRC-1:0] rdata_q
);

    logic [NUM_SRC-1:0] rd_word;

    // Choose the word for the selected register.
    always_comb begin
        case (rd_sel)
            SEL_STAT0: rd_word = stat0_i;
            SEL_STAT1: rd_word = stat1_i;
            SEL_STEER: rd_word = steer_i;
            SEL_RAW:   rd_word = raw_i;
            SEL_ENSET: rd_word = mask_i;
            default:   rd_word = '0;
        endcase
    end

    // Capture on a read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_word;
    end

endmodule

// File: rtl/intc_dual_out.sv
// Module: top of the two-output level interrupt controller.
// Decodes single-cycle bus strobes, keeps mask and steering state, and
// drives two registered request lines. Sources are assumed synchronous
// to clk.
module intc_dual_out
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] src_i,
    output logic               irq0_o,
    output logic               irq1_o
);

    localparam int unsigned NUM_OUT = 2;
    localparam int unsigned PAD_W   = DEC_W - ADDR_W;

    reg_sel_e           acc_sel;
    logic               wr_en;
    logic               rd_en;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] steer_q;
    logic [NUM_SRC-1:0] stat_w [NUM_OUT];
    logic [NUM_SRC-1:0] stat0_w;
    logic [NUM_SRC-1:0] stat1_w;
    logic               irq_w  [NUM_OUT];

    // Decode the byte offset and split the strobe into read and write.
    always_comb begin
        acc_sel = decode_off({{PAD_W{1'b0}}, bus_addr});
        wr_en   = bus_sel &  bus_we;
        rd_en   = bus_sel & ~bus_we;
    end

    intc_ctrl_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (acc_sel),
        .wr_data (bus_wdata),
        .mask_q  (mask_q),
        .steer_q (steer_q)
    );

    intc_steer #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_steer (
        .raw_i   (src_i),
        .mask_i  (mask_q),
        .steer_i (steer_q),
        .stat_o  (stat_w)
    );

    // Named status words for the read path and the checker.
    always_comb begin
        stat0_w = stat_w[0];
        stat1_w = stat_w[1];
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_line
        intc_irq_line #(.NUM_SRC(NUM_SRC)) u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .stat_i (stat_w[k]),
            .irq_q  (irq_w[k])
        );
    end

    // Drive the output pins from the line registers.
    always_comb begin
        irq0_o = irq_w[0];
        irq1_o = irq_w[1];
    end

    intc_rd_mux #(.NUM_SRC(NUM_SRC)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_sel  (acc_sel),
        .stat0_i (stat0_w),
        .stat1_i (stat1_w),
        .raw_i   (src_i),
        .mask_i  (mask_q),
        .steer_i (steer_q),
        .rdata_q (bus_rdata)
    );

endmodule

// File: rtl/intc_dual_out_chk.sv
// Checker: temporal properties of the two-output controller, bound to
// the top module.
module intc_dual_out_chk
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NUM_SRC-1:0] bus_wdata,
    input logic [NUM_SRC-1:0] bus_rdata,
    input logic               irq0_o,
    input logic               irq1_o,
    input logic [NUM_SRC-1:0] mask,
    input logic [NUM_SRC-1:0] stat0,
    input logic [NUM_SRC-1:0] stat1
);

    localparam int unsigned GBIT  = NUM_SRC - 1;
    localparam int unsigned PAD_W = DEC_W - ADDR_W;

    reg_sel_e sel_c;
    always_comb sel_c = decode_off({{PAD_W{1'b0}}, bus_addr});

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!irq0_o && !irq1_o && bus_rdata == '0));

    // R2
    set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && sel_c == SEL_ENSET)
        |=> ((mask & $past(bus_wdata)) == $past(bus_wdata)));

    // R3
    clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && sel_c == SEL_ENCLR)
        |=> ((mask & $past(bus_wdata)) == '0));

    // R4
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask[GBIT] |=> (!irq0_o && !irq1_o));

    // R5
    no_dual_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0 & stat1) == '0);

    // R7
    gate_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat0[GBIT] && !stat1[GBIT]);

    // R8
    line0_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat0) |=> irq0_o);

    // R8
    line1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat1 == '0) |=> !irq1_o);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> $stable(bus_rdata));

endmodule

bind intc_dual_out intc_dual_out_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq0_o    (irq0_o),
    .irq1_o    (irq1_o),
    .mask      (mask_q),
    .stat0     (stat0_w),
    .stat1     (stat1_w)
);

// File: tb/intc_dual_out_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus
// directed register reads with hand-computed expected words.
module intc_dual_out_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_i = '0;
    logic        irq0_o;
    logic        irq1_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit live   = 1'b0;

    intc_dual_out u_intc_dual_out (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_i(src_i), .irq0_o(irq0_o), .irq1_o(irq1_o)
    );

    always #10 clk = ~clk;

    // Reference model state.
    logic [31:0] m_mask, m_steer, e_rdata;
    logic        e_irq0, e_irq1;

    function automatic logic [31:0] m_stat(input int k, input logic [31:0] s,
                                           input logic [31:0] mk, input logic [31:0] st);
        logic [31:0] w;
        w = '0;
        if (mk[31])
            for (int i = 0; i < 31; i++)
                if (s[i] && mk[i] && (int'(st[i]) == k)) w[i] = 1'b1;
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = '0; m_steer = '0; e_rdata = '0; e_irq0 = 0; e_irq1 = 0;
        end else begin
            e_irq0 = (m_stat(0, src_i, m_mask, m_steer) != 0);
            e_irq1 = (m_stat(1, src_i, m_mask, m_steer) != 0);
            if (bus_sel && !bus_we) begin
                case (bus_addr)
                    8'h00: e_rdata = m_stat(0, src_i, m_mask, m_steer);
                    8'h04: e_rdata = m_stat(1, src_i, m_mask, m_steer);
                    8'h20: e_rdata = m_steer;
                    8'h30: e_rdata = src_i;
                    8'h34: e_rdata = m_mask;
                    default: e_rdata = '0;
                endcase
            end
            if (bus_sel && bus_we) begin
                if (bus_addr == 8'h34) m_mask = m_mask | bus_wdata;
                if (bus_addr == 8'h38) m_mask = m_mask & ~bus_wdata;
                if (bus_addr == 8'h20) m_steer = bus_wdata;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (live && rst_n && !done) begin
            check("R8 irq0 model", {31'd0, irq0_o}, {31'd0, e_irq0});
            check("R8 irq1 model", {31'd0, irq1_o}, {31'd0, e_irq1});
            check("R11 rdata model", bus_rdata, e_rdata);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        check(tag, bus_rdata, exp);
    endtask

    task automatic lines(input logic i0, input logic i1, input string tag);
        check(tag, {30'd0, irq1_o, irq0_o}, {30'd0, i1, i0});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 5000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; live = 1;
        // R1: reset state
        lines(0, 0, "R1 lines after reset");
        check("R1 rdata after reset", bus_rdata, 32'h0);
        rd(8'h34, 32'h0, "R1 mask after reset");
        rd(8'h20, 32'h0, "R1 steer after reset");

        src_i = 32'h0000_00F0;
        rd(8'h30, 32'h0000_00F0, "R6 raw with mask clear");
        wr(8'h34, 32'h0000_0030);
        rd(8'h34, 32'h0000_0030, "R2 set low bits");
        rd(8'h00, 32'h0, "R4 status0 gate off");
        lines(0, 0, "R4 lines gate off");

        wr(8'h34, 32'h8000_0000);
        lines(0, 0, "R8 line not yet updated");
        @(negedge clk);
        lines(1, 0, "R8 line one clock later");
        rd(8'h34, 32'h8000_0030, "R2 zero bits unchanged");
        rd(8'h00, 32'h0000_0030, "R7 status0");
        rd(8'h04, 32'h0, "R7 status1 empty");

        wr(8'h20, 32'h0000_0020);
        rd(8'h00, 32'h0000_0010, "R5 status0 after steer");
        rd(8'h04, 32'h0000_0020, "R5 status1 after steer");
        lines(1, 1, "R5 both lines");
        rd(8'h00, 32'h0000_0010, "R10 status0 not cleared by read");

        src_i = 32'h0000_00E0;
        rd(8'h00, 32'h0, "R10 status0 follows level");
        lines(0, 1, "R10 line0 drops with source");

        wr(8'h38, 32'h0000_0020);
        rd(8'h34, 32'h8000_0010, "R3 partial clear");
        rd(8'h04, 32'h0, "R3 status1 after clear");
        lines(0, 0, "R3 lines after clear");

        rd(8'h38, 32'h0, "R9 clear offset reads zero");
        rd(8'h44, 32'h0, "R9 unmapped reads zero");
        rd(8'h20, 32'h0000_0020, "R9 steer readback");

        src_i = 32'hFFFF_FFFF;
        wr(8'h34, 32'hFFFF_FFFF);
        rd(8'h30, 32'hFFFF_FFFF, "R6 raw all high");
        rd(8'h00, 32'h7FFF_FFDF, "R7 status0 bit31 zero");
        rd(8'h04, 32'h0000_0020, "R7 status1 bit31 zero");

        wr(8'h38, 32'h8000_0000);
        @(negedge clk);
        lines(0, 0, "R4 gate cleared alone");
        rd(8'h04, 32'h0, "R4 status1 gate off");

        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h34, 32'h0, "R3 clear all");
        rd(8'h30, 32'hFFFF_FFFF, "R6 raw mask empty");
        lines(0, 0, "R3 lines after clear all");

        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        rd(8'h20, 32'h0, "R1 steer after second reset");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule